// File: doc/BRIEF.md
# Link Receive Responder

This block sits on the receive side of a serial storage link, after the physical layer has decoded incoming 32-bit dwords and flagged control characters. For every dword that arrives, it picks the primitive to send back to the far end. It answers a transmit request with a receiver-ready, reports reception in progress while a frame is open, and acknowledges the far end's holds. It asks for a hold itself when the consumer downstream is stalled, and it reports a good end when termination arrives.

Between start-of-frame and end-of-frame, the block gathers the payload dwords and presents them on a valid/ready/last stream. The final dword before end-of-frame is still in scrambled or CRC form, and it goes out tagged `last` so that a later stage can check it. The block holds back one dword so that the last flag can be attached to it. A small FIFO absorbs the dwords that are still in flight after a hold has been requested.

Top module: `lrx_responder`

## Requirements
- R1: After reset, `tx_prim` equals the idle code 32'hB5B5957C and `out_valid` is 0.
- R2: A cycle with `rx_valid` low changes neither `tx_prim` nor the payload stream contents.
- R3: A control dword (`rx_isk`=1) equal to the transmit-request code 32'h5757B57C sets `tx_prim` to the receiver-ready code 32'h4A4A957C on the next cycle.
- R4: A control dword equal to the start code 32'h3737B57C opens a frame, sets `tx_prim` to the in-progress code 32'h5555B57C, and discards a held dword of an earlier unterminated frame.
- R5: While a frame is open and before its end code arrives, each dword with `rx_isk`=0 is forwarded in arrival order, even if its value equals a primitive code. Control dwords are never forwarded, and dwords received outside a frame are ignored.
- R6: While a frame is open, any dword that is not a named primitive sets `tx_prim` to the in-progress code when `out_ready` is 1, and to the hold code 32'hD5D5AA7C when `out_ready` is 0.
- R7: A control dword equal to the hold code sets `tx_prim` to the hold-acknowledge code 32'h9595AA7C, inside or outside a frame.
- R8: A control dword equal to the end code 32'hD5D5B57C leaves `tx_prim` unchanged. It releases the final payload dword, which is the CRC, with `out_last`=1.
- R9: A control dword equal to the terminate code 32'h5858B57C sets `tx_prim` to the good-end code 32'h3535B57C and closes the frame. A held dword with no end code before it is dropped.
- R10: Outside a frame, any other dword sets `tx_prim` to the idle code. `tx_prim` is registered: it changes on the clock edge that accepts the dword.
- R11: While `out_ready` is low, up to FIFO_DEPTH payload dwords are kept, and `out_valid`, `out_data` and `out_last` stay stable. After release, they are delivered in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | An incoming dword is present this cycle |
| rx_data | input | 32 | Incoming decoded dword |
| rx_isk | input | 1 | Incoming dword is a control character |
| tx_prim | output | 32 | Primitive to transmit back |
| out_valid | output | 1 | Payload stream valid |
| out_data | output | 32 | Payload stream dword |
| out_last | output | 1 | Final dword of the frame (CRC) |
| out_ready | input | 1 | Downstream can accept a dword |

## Verification
The bench feeds a dword that carries a primitive's value but has the control flag clear. A design that decodes by value alone would drop that payload dword or change its reply. It also restarts a frame with a second start code while a dword is held. A design that does not clear the holding register would leak a stale dword into the new frame. A frame is also terminated with no end code, and a design that flushes on termination would emit a spurious dword. Finally, the stream is stalled for a whole frame. A design that loses in-flight dwords, mis-places `last`, or replies in-progress instead of hold while stalled shows up in both the reply and the delivered stream.

// File: rtl/lrx_pkg.sv
package lrx_pkg;
  localparam int unsigned DW = 32;

  localparam logic [DW-1:0] PRIM_SYNC  = 32'hB5B5957C;
  localparam logic [DW-1:0] PRIM_XRDY  = 32'h5757B57C;
  localparam logic [DW-1:0] PRIM_RRDY  = 32'h4A4A957C;
  localparam logic [DW-1:0] PRIM_SOF   = 32'h3737B57C;
  localparam logic [DW-1:0] PRIM_EOF   = 32'hD5D5B57C;
  localparam logic [DW-1:0] PRIM_WTRM  = 32'h5858B57C;
  localparam logic [DW-1:0] PRIM_HOLD  = 32'hD5D5AA7C;
  localparam logic [DW-1:0] PRIM_HOLDA = 32'h9595AA7C;
  localparam logic [DW-1:0] PRIM_RIP   = 32'h5555B57C;
  localparam logic [DW-1:0] PRIM_ROK   = 32'h3535B57C;

  typedef enum logic [2:0] {
    K_DATA, K_XRDY, K_SOF, K_EOF, K_WTRM, K_HOLD, K_OTHER
  } dw_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_FRAME, ST_TAIL
  } rx_state_e;
endpackage

// File: rtl/lrx_classify.sv
module lrx_classify
  import lrx_pkg::*;
(
  input  logic [DW-1:0] data,
  input  logic          isk,
  output dw_kind_e      kind
);
  always_comb begin
    kind = K_DATA;
    if (isk) begin
      unique case (data)
        PRIM_XRDY: kind = K_XRDY;
        PRIM_SOF:  kind = K_SOF;
        PRIM_EOF:  kind = K_EOF;
        PRIM_WTRM: kind = K_WTRM;
        PRIM_HOLD: kind = K_HOLD;
        default:   kind = K_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/lrx_reply_fsm.sv
module lrx_reply_fsm
  import lrx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dw_valid,
  input  dw_kind_e      kind,
  input  logic          out_ready,
  output logic [DW-1:0] reply,
  output logic          append,
  output logic          flush,
  output logic          clear
);
  rx_state_e     st_q, st_d;
  logic [DW-1:0] rep_d;
  logic          upd_en;

  assign upd_en = dw_valid;

  always_comb begin
    st_d   = st_q;
    rep_d  = reply;
    append = 1'b0;
    flush  = 1'b0;
    clear  = 1'b0;
    if (dw_valid) begin
      unique case (kind)
        K_XRDY: begin
          rep_d = PRIM_RRDY;
          st_d  = ST_IDLE;
          clear = 1'b1;
        end
        K_WTRM: begin
          rep_d = PRIM_ROK;
          st_d  = ST_IDLE;
          clear = 1'b1;
        end
        K_HOLD: rep_d = PRIM_HOLDA;
        K_EOF: begin
          if (st_q == ST_FRAME) begin
            flush = 1'b1;
            st_d  = ST_TAIL;
          end
        end
        K_SOF: begin
          rep_d = PRIM_RIP;
          st_d  = ST_FRAME;
          clear = 1'b1;
        end
        default: begin
          if (st_q != ST_IDLE) begin
            rep_d  = out_ready ? PRIM_RIP : PRIM_HOLD;
            append = (st_q == ST_FRAME) && (kind == K_DATA);
          end else begin
            rep_d = PRIM_SYNC;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      reply <= PRIM_SYNC;
    end else if (upd_en) begin
      st_q  <= st_d;
      reply <= rep_d;
    end
  end
endmodule

// File: rtl/lrx_tail_buf.sv
module lrx_tail_buf
  import lrx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          append,
  input  logic          flush,
  input  logic          clear,
  input  logic [DW-1:0] in_data,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic          push_last
);
  logic          held_q, held_d;
  logic [DW-1:0] word_q;
  logic          word_en;

  always_comb begin
    held_d    = held_q;
    push      = 1'b0;
    push_last = 1'b0;
    push_data = word_q;
    word_en   = 1'b0;
    if (clear) begin
      held_d = 1'b0;
    end else if (append) begin
      push    = held_q;
      held_d  = 1'b1;
      word_en = 1'b1;
    end else if (flush) begin
      push      = held_q;
      push_last = 1'b1;
      held_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      word_q <= '0;
    end else begin
      held_q <= held_d;
      if (word_en) word_q <= in_data;
    end
  end
endmodule

// File: rtl/lrx_fifo.sv
module lrx_fifo #(
  parameter int unsigned W     = 33,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_wr, do_rd;

  assign full  = (cnt_q == CNT_MAX);
  assign empty = (cnt_q == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign rdata = mem[rp_q];

  always_comb begin
    cnt_d = cnt_q;
    if (do_wr && !do_rd) cnt_d = cnt_q + 1'b1;
    else if (do_rd && !do_wr) cnt_d = cnt_q - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = do_wr && (wp_q == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= '0;
      else if (slot_en) mem[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= (wp_q == PTR_MAX) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_q <= (rp_q == PTR_MAX) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/lrx_responder.sv
module lrx_responder
  import lrx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [31:0]   rx_data,
  input  logic          rx_isk,
  output logic [31:0]   tx_prim,
  output logic          out_valid,
  output logic [31:0]   out_data,
  output logic          out_last,
  input  logic          out_ready
);
  localparam int unsigned FW = DW + 1;

  dw_kind_e      kind;
  logic          append, flush, clear;
  logic          fifo_push, fifo_full, fifo_empty;
  logic [DW-1:0] push_data;
  logic          push_last;
  logic [FW-1:0] head;

  lrx_classify u_cls (
    .data (rx_data),
    .isk  (rx_isk),
    .kind (kind)
  );

  lrx_reply_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .dw_valid  (rx_valid),
    .kind      (kind),
    .out_ready (out_ready),
    .reply     (tx_prim),
    .append    (append),
    .flush     (flush),
    .clear     (clear)
  );

  lrx_tail_buf u_tail (
    .clk       (clk),
    .rst_n     (rst_n),
    .append    (append),
    .flush     (flush),
    .clear     (clear),
    .in_data   (rx_data),
    .push      (fifo_push),
    .push_data (push_data),
    .push_last (push_last)
  );

  lrx_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .wdata ({push_last, push_data}),
    .pop   (out_valid && out_ready),
    .rdata (head),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  assign out_valid = !fifo_empty;
  assign out_data  = head[DW-1:0];
  assign out_last  = head[DW];
endmodule

// File: rtl/lrx_checker.sv
module lrx_checker
  import lrx_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic [31:0] rx_data,
  input logic        rx_isk,
  input logic [31:0] tx_prim,
  input logic        out_valid,
  input logic [31:0] out_data,
  input logic        out_last,
  input logic        out_ready,
  input logic        fifo_push,
  input logic        fifo_full
);
  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(tx_prim));

  assert_xrdy_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_isk && rx_data == PRIM_XRDY) |=> (tx_prim == PRIM_RRDY));

  assert_sof_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_isk && rx_data == PRIM_SOF) |=> (tx_prim == PRIM_RIP));

  assert_hold_reply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_isk && rx_data == PRIM_HOLD) |=> (tx_prim == PRIM_HOLDA));

  assert_eof_keeps_reply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_isk && rx_data == PRIM_EOF) |=> $stable(tx_prim));

  assert_wtrm_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_isk && rx_data == PRIM_WTRM) |=> (tx_prim == PRIM_ROK));

  assert_stall_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full);
endmodule

bind lrx_responder lrx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .rx_data   (rx_data),
  .rx_isk    (rx_isk),
  .tx_prim   (tx_prim),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_last  (out_last),
  .out_ready (out_ready),
  .fifo_push (fifo_push),
  .fifo_full (fifo_full)
);

// File: tb/sim_lrx_responder.sv
`timescale 1ns/1ps
module sim_lrx_responder;
  import lrx_pkg::*;

  localparam logic [31:0] ALIGN_K = 32'h7B4A4ABC;
  localparam int NV = 21;
  // {isk, data, out_ready, expected reply}
  localparam logic [65:0] VEC [NV] = '{
    {1'b1, PRIM_SYNC,    1'b1, PRIM_SYNC },  // R10 idle
    {1'b1, PRIM_XRDY,    1'b1, PRIM_RRDY },  // R3
    {1'b1, PRIM_SOF,     1'b1, PRIM_RIP  },  // R4
    {1'b0, 32'hA0000001, 1'b1, PRIM_RIP  },  // R6
    {1'b0, 32'hA0000002, 1'b1, PRIM_RIP  },
    {1'b0, 32'hA0000003, 1'b0, PRIM_HOLD },  // R6 stalled
    {1'b1, PRIM_HOLD,    1'b1, PRIM_HOLDA},  // R7
    {1'b0, 32'hA0000004, 1'b1, PRIM_RIP  },
    {1'b1, PRIM_EOF,     1'b1, PRIM_RIP  },  // R8 unchanged
    {1'b1, PRIM_WTRM,    1'b1, PRIM_ROK  },  // R9
    {1'b1, PRIM_SYNC,    1'b1, PRIM_SYNC },  // R10
    {1'b0, 32'hDEAD0000, 1'b1, PRIM_SYNC },  // R5 ignored outside frame
    {1'b1, PRIM_XRDY,    1'b1, PRIM_RRDY },
    {1'b1, PRIM_SOF,     1'b1, PRIM_RIP  },
    {1'b0, 32'hB0000001, 1'b1, PRIM_RIP  },  // held, then dropped
    {1'b1, PRIM_SOF,     1'b1, PRIM_RIP  },  // R4 restart
    {1'b0, 32'hC0000001, 1'b1, PRIM_RIP  },
    {1'b1, ALIGN_K,      1'b1, PRIM_RIP  },  // R5 control not forwarded
    {1'b0, PRIM_SYNC,    1'b1, PRIM_RIP  },  // R5 data with primitive value
    {1'b1, PRIM_EOF,     1'b1, PRIM_RIP  },
    {1'b1, PRIM_WTRM,    1'b1, PRIM_ROK  }
  };

  logic        clk, rst_n, rx_valid, rx_isk, out_ready;
  logic [31:0] rx_data, tx_prim, out_data;
  logic        out_valid, out_last;

  int n_chk = 0, n_bad = 0;
  logic [32:0] exp_str [64];
  int exp_wr = 0, got_rd = 0;
  bit done = 0;

  lrx_responder u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_isk(rx_isk), .tx_prim(tx_prim), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_word(input logic [31:0] d, input logic l);
    exp_str[exp_wr] = {l, d};
    exp_wr++;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic apply(input logic k, input logic [31:0] d, input logic rdy,
                       input logic [31:0] exp, input string req);
    rx_valid  = 1'b1;
    rx_isk    = k;
    rx_data   = d;
    out_ready = rdy;
    @(negedge clk);
    check(tx_prim === exp, req, 64'(tx_prim), 64'(exp));
  endtask

  task automatic idle_cycles(input int n);
    rx_valid  = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // stream monitor: R5/R8/R11 ordering and last flag
  always begin
    @(negedge clk);
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (got_rd >= exp_wr) begin
        check(1'b0, "R5 unexpected dword", 64'({out_last, out_data}), 64'h0);
      end else begin
        check({out_last, out_data} === exp_str[got_rd], "R5/R8 stream",
              64'({out_last, out_data}), 64'(exp_str[got_rd]));
      end
      got_rd++;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_valid = 1'b0; rx_isk = 1'b0; rx_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_prim === PRIM_SYNC, "R1 reply", 64'(tx_prim), 64'(PRIM_SYNC));
    check(out_valid === 1'b0, "R1 valid", 64'(out_valid), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    expect_word(32'hA0000001, 1'b0);
    expect_word(32'hA0000002, 1'b0);
    expect_word(32'hA0000003, 1'b0);
    expect_word(32'hA0000004, 1'b1);
    expect_word(32'hC0000001, 1'b0);
    expect_word(PRIM_SYNC,    1'b1);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][65], VEC[i][64:33], VEC[i][32], VEC[i][31:0], "R3-R10 table");
    end
    idle_cycles(4);
    check(got_rd == exp_wr, "R5 table count", 64'(got_rd), 64'(exp_wr));

    // R2: dword without rx_valid is ignored
    rx_valid = 1'b0; rx_isk = 1'b1; rx_data = PRIM_XRDY; out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(tx_prim === PRIM_ROK, "R2 reply held", 64'(tx_prim), 64'(PRIM_ROK));
    check(out_valid === 1'b0, "R2 no output", 64'(out_valid), 64'h0);

    // R11: whole frame while stalled
    apply(1'b1, PRIM_XRDY, 1'b0, PRIM_RRDY, "R3 stall frame");
    apply(1'b1, PRIM_SOF,  1'b0, PRIM_RIP,  "R4 stall frame");
    for (int i = 0; i < 5; i++) begin
      apply(1'b0, 32'hE0000000 + 32'(i), 1'b0, PRIM_HOLD, "R6 hold while stalled");
      expect_word(32'hE0000000 + 32'(i), i == 4);
    end
    apply(1'b1, PRIM_EOF, 1'b0, PRIM_HOLD, "R8 eof keeps hold");
    check(out_valid === 1'b1 && out_data === 32'hE0000000, "R11 head held",
          64'({out_valid, out_data}), 64'({1'b1, 32'hE0000000}));
    apply(1'b1, PRIM_WTRM, 1'b0, PRIM_ROK, "R9 stall frame");
    check(out_valid === 1'b1 && out_data === 32'hE0000000, "R11 head still held",
          64'({out_valid, out_data}), 64'({1'b1, 32'hE0000000}));
    idle_cycles(10);
    check(got_rd == exp_wr, "R11 drained count", 64'(got_rd), 64'(exp_wr));

    // R9: termination without end code drops held dword
    apply(1'b1, PRIM_SOF, 1'b1, PRIM_RIP, "R4 no-eof frame");
    apply(1'b0, 32'hF0000001, 1'b1, PRIM_RIP, "R6 no-eof frame");
    expect_word(32'hF0000001, 1'b0);
    apply(1'b0, 32'hF0000002, 1'b1, PRIM_RIP, "R6 no-eof frame");
    apply(1'b1, PRIM_WTRM, 1'b1, PRIM_ROK, "R9 no-eof frame");
    apply(1'b1, PRIM_HOLD, 1'b1, PRIM_HOLDA, "R7 outside frame");
    apply(1'b1, ALIGN_K, 1'b1, PRIM_SYNC, "R10 other primitive idle");
    idle_cycles(6);
    check(got_rd == exp_wr, "R9 dropped dword count", 64'(got_rd), 64'(exp_wr));
    check(out_valid === 1'b0, "R9 stream empty", 64'(out_valid), 64'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule